// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the clock line of an I2C master. It divides a source clock in three nested stages. A fixed prescaler comes first. A step counter follows, and then an interval counter. The last interval-counter wrap ends one half of an SCL period. The transaction engine starts the block by raising `run_i`. From then on the block reports each half-period boundary, whether the current half is the SCL-high half, and one strobe per high half at which SDA should be sampled.

Two configuration words supply the counts, and software computes both of them. The normal word serves standard and fast speeds. The high-speed word replaces it when its two enable bits are set. In high-speed mode the step range is narrower. Every count is stored minus one. A half period therefore lasts `PREDIV × sample_cnt × step_cnt` source cycles, and a full SCL period lasts twice that.

Top module: `i2c_scl_timer`

## Requirements
- R1: With `run_i` high, `half_tick_o` pulses for one cycle in the last cycle of each half period. A half period lasts `PREDIV × sample_cnt × step_cnt` source cycles. The first pulse comes in cycle L−1, where L is the half length and cycle 0 is the first cycle with `run_i` high.
- R2: In normal mode, `norm_cfg_i[5:0]` holds step_cnt−1 (1..64) and `norm_cfg_i[10:8]` holds sample_cnt−1 (1..8). The other bits of that word have no effect.
- R3: When `hs_cfg_i[1:0]` equals 2'b11, high-speed timing is used. In that case `hs_cfg_i[14:12]` holds sample_cnt−1 (1..8) and `hs_cfg_i[10:8]` holds step_cnt−1 (1..8), `norm_cfg_i` is ignored, and `hs_mode_o` is 1 for every half timed this way.
- R4: When `hs_cfg_i[1:0]` is not 2'b11, for example when the word is zero, normal timing is used, the rest of `hs_cfg_i` has no effect, and `hs_mode_o` is 0.
- R5: While `run_i` is low, all counters and the phase are held at zero and neither pulse is produced. After `run_i` is raised again, the first half has its full length, even if the previous run stopped partway through a half.
- R6: `sample_o` pulses exactly once in each SCL-high half. The pulse is in the first cycle of interval number floor((sample_cnt−1)/2), counting intervals from 0. That cycle lies `idx × step_cnt × PREDIV` cycles after the start of the high half.
- R7: `scl_high_o` is 0 during the first half after `run_i` rises and inverts after every `half_tick_o`.
- R8: A configuration change made partway through a half does not alter that half's length, its sample point or `hs_mode_o`. The change applies from the next half onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Enable from the transaction engine |
| norm_cfg_i | input | 16 | Normal-mode timing word |
| hs_cfg_i | input | 16 | High-speed timing word with enable bits [1:0] |
| half_tick_o | output | 1 | Last cycle of each SCL half period |
| sample_o | output | 1 | SDA sample strobe in the SCL-high half |
| scl_high_o | output | 1 | Current half is the SCL-high half |
| hs_mode_o | output | 1 | Current half is timed by the high-speed word |

## Verification
All four outputs are decoded directly from registered state, so each one is valid in the same cycle as the counter state it reflects. The half tick falls in cycle L−1 after `run_i` rises. The sample strobe falls `L + idx·step·PREDIV` cycles in. A configuration written in cycle c is first seen in the half that follows the next boundary. The bench raises `run_i` on a falling edge and calls that cycle 0. Its reference model walks the same cycle index, with each half length taken from the configuration that was present at the boundary before that half. It samples every output 1 ns after the falling edge, once the registers have settled and well before the next rising edge. It then compares the outputs cycle by cycle against the model.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  localparam int SAMP_W    = 3;
  localparam int STEP_W    = 6;
  localparam int HS_STEP_W = 3;

  typedef struct packed {
    logic              hs;
    logic [SAMP_W-1:0] samp_m1;
    logic [STEP_W-1:0] step_m1;
  } tcfg_t;
endpackage

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic first_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o  = run_i;
      assign first_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!run_i)             cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign tick_o  = run_i && (cnt_q == LAST);
      assign first_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/sclgen_modcnt.sv
module sclgen_modcnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q, val_d;

  assign wrap_o = adv_i && (val_q == last_i);

  always_comb begin
    val_d = val_q;
    if (clr_i)       val_d = '0;
    else if (wrap_o) val_d = '0;
    else if (adv_i)  val_d = val_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/sclgen_cfgsel.sv
module sclgen_cfgsel
  import sclgen_pkg::*;
(
  input  logic [15:0] norm_cfg_i,
  input  logic [15:0] hs_cfg_i,
  output tcfg_t       cfg_o
);
  always_comb begin
    cfg_o.hs = (hs_cfg_i[1:0] == 2'b11);
    if (cfg_o.hs) begin
      cfg_o.samp_m1 = hs_cfg_i[14:12];
      cfg_o.step_m1 = {{(STEP_W-HS_STEP_W){1'b0}}, hs_cfg_i[10:8]};
    end else begin
      cfg_o.samp_m1 = norm_cfg_i[10:8];
      cfg_o.step_m1 = norm_cfg_i[5:0];
    end
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import sclgen_pkg::*;
#(
  parameter int PREDIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic [15:0] norm_cfg_i,
  input  logic [15:0] hs_cfg_i,
  output logic        half_tick_o,
  output logic        sample_o,
  output logic        scl_high_o,
  output logic        hs_mode_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tcfg_t cfg_new, cfg_q, cfg_d;
  logic  phase_q, phase_d;
  logic  pre_tick, pre_first;
  logic  step_wrap, half_end;
  logic [STEP_W-1:0] step_val;
  logic [SAMP_W-1:0] intv_val;
  logic              cfg_en;

  sclgen_cfgsel u_sel (
    .norm_cfg_i (norm_cfg_i),
    .hs_cfg_i   (hs_cfg_i),
    .cfg_o      (cfg_new)
  );

  sclgen_prescale #(.DIV(PREDIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (run_i),
    .tick_o  (pre_tick),
    .first_o (pre_first)
  );

  sclgen_modcnt #(.W(STEP_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (!run_i),
    .adv_i  (pre_tick),
    .last_i (cfg_q.step_m1),
    .val_o  (step_val),
    .wrap_o (step_wrap)
  );

  sclgen_modcnt #(.W(SAMP_W)) u_intv (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (!run_i),
    .adv_i  (step_wrap),
    .last_i (cfg_q.samp_m1),
    .val_o  (intv_val),
    .wrap_o (half_end)
  );

  // configuration is taken only while idle or at a half boundary
  assign cfg_en = !run_i || half_end;

  always_comb begin
    cfg_d   = cfg_en ? cfg_new : cfg_q;
    phase_d = phase_q;
    if (!run_i)        phase_d = 1'b0;
    else if (half_end) phase_d = !phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      phase_q <= phase_d;
    end
  end

  assign half_tick_o = half_end;
  assign sample_o    = run_i && phase_q && pre_first && (step_val == '0) &&
                       (intv_val == (cfg_q.samp_m1 >> 1));
  assign scl_high_o  = phase_q;
  assign hs_mode_o   = cfg_q.hs;
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic half_tick_o,
  input logic sample_o,
  input logic scl_high_o,
  input logic hs_mode_o
);
  // R5: nothing pulses while idle
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!half_tick_o && !sample_o));

  // R5: an idle cycle leaves the phase at zero
  a_r5_phase_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run_i) |-> !scl_high_o);

  // R6: the strobe only falls in the high half
  a_r6_sample_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> scl_high_o);

  // R6: one strobe per high half, never in back-to-back cycles
  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  // R7: every half boundary inverts the phase
  a_r7_phase_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(half_tick_o) |-> (scl_high_o != $past(scl_high_o)));

  // R8: the mode stays fixed inside a running half
  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(half_tick_o)) |-> $stable(hs_mode_o));
endmodule

bind i2c_scl_timer sclgen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .half_tick_o (half_tick_o),
  .sample_o    (sample_o),
  .scl_high_o  (scl_high_o),
  .hs_mode_o   (hs_mode_o)
);

// File: tb/sim_i2c_scl_timer.sv
`timescale 1ns/1ps
module sim_i2c_scl_timer;
  localparam int P = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic run;
  logic [15:0] ncfg, hcfg;
  logic half_tick, sample, scl_high, hs_mode;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #2.5 clk = !clk;

  i2c_scl_timer #(.PREDIV(P)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .run_i (run),
    .norm_cfg_i (ncfg), .hs_cfg_i (hcfg),
    .half_tick_o (half_tick), .sample_o (sample),
    .scl_high_o (scl_high), .hs_mode_o (hs_mode)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic void dec(input logic [15:0] n, input logic [15:0] h,
                              output int s, output int st, output int hs);
    hs = (h[1:0] == 2'b11) ? 1 : 0;
    if (hs == 1) begin
      s = int'(h[14:12]) + 1; st = int'(h[10:8]) + 1;
    end else begin
      s = int'(n[10:8]) + 1;  st = int'(n[5:0]) + 1;
    end
  endfunction

  // Runs from idle; cfg A is in place at start, cfg B is applied at cycle chg.
  task automatic run_case(input string rq, input logic [15:0] na, input logic [15:0] ha,
                          input logic [15:0] nb, input logic [15:0] hb,
                          input int chg, input int halves);
    int sa, sta, hsa, sb, stb, hsb;
    int cs, cst, chs, start, h, p, len;
    int m_tick, m_samp, m_high, m_hs, nticks, nsamp;
    int e_tick, e_samp, e_high;
    dec(na, ha, sa, sta, hsa);
    dec(nb, hb, sb, stb, hsb);
    m_tick = 0; m_samp = 0; m_high = 0; m_hs = 0; nticks = 0; nsamp = 0;
    @(negedge clk); ncfg = na; hcfg = ha;
    repeat (3) @(negedge clk);
    run = 1'b1;
    cs = sa; cst = sta; chs = hsa; start = 0; h = 0;
    for (int c = 0; h < halves; c++) begin
      if (c > 0) @(negedge clk);
      if (c == chg) begin ncfg = nb; hcfg = hb; end
      #1;
      p = c - start; len = P * cs * cst;
      e_tick = (p == len - 1) ? 1 : 0;
      e_high = h % 2;
      e_samp = (e_high == 1 && p == ((cs - 1) / 2) * cst * P) ? 1 : 0;
      if (int'(half_tick) != e_tick) begin
        if (m_tick == 0) $display("  tick miss at cycle %0d", c);
        m_tick++;
      end
      if (int'(sample) != e_samp) begin
        if (m_samp == 0) $display("  sample miss at cycle %0d", c);
        m_samp++;
      end
      if (int'(scl_high) != e_high) m_high++;
      if (int'(hs_mode) != chs) m_hs++;
      nticks += int'(half_tick);
      nsamp  += int'(sample);
      if (e_tick == 1) begin
        start = c + 1; h++;
        if (c >= chg) begin cs = sb; cst = stb; chs = hsb; end
      end
    end
    @(negedge clk); run = 1'b0;
    chk(rq, "half_tick cycle mismatches", m_tick, 0);
    chk(rq, "sample cycle mismatches", m_samp, 0);
    chk(rq, "scl_high mismatches", m_high, 0);
    chk(rq, "hs_mode mismatches", m_hs, 0);
    chk(rq, "half tick count", nticks, halves);
    chk(rq, "sample count", nsamp, halves / 2);
  endtask

  task automatic t_reset();
    #1;
    chk("R5", "reset half_tick", int'(half_tick), 0);
    chk("R5", "reset sample", int'(sample), 0);
    chk("R7", "reset scl_high", int'(scl_high), 0);
    chk("R4", "reset hs_mode", int'(hs_mode), 0);
  endtask

  task automatic t_idle_abort();
    int seen;
    seen = 0;
    @(negedge clk); ncfg = 16'h0302; hcfg = 16'h0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (30) @(negedge clk);   // stop partway through the second half
    run = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (i > 0) seen += int'(half_tick) + int'(sample) + int'(scl_high);
      else       seen += int'(half_tick) + int'(sample);
    end
    chk("R5", "activity while idle", seen, 0);
    // restart: first half must be full length
    run_case("R5", 16'h0302, 16'h0, 16'h0302, 16'h0, -1, 3);
  endtask

  initial begin
    run = 1'b0; ncfg = '0; hcfg = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 R2 R6 R7: sample 4, step 3, half 24
    run_case("R1", 16'h0302, 16'h0000, 16'h0302, 16'h0000, -1, 4);
    // R2: upper stray bits of normal word ignored, minimum counts
    run_case("R2", 16'hF0C0, 16'h0000, 16'hF0C0, 16'h0000, -1, 4);
    // R2 R6: maximum counts, sample 8 step 64
    run_case("R6", 16'h073F, 16'h0000, 16'h073F, 16'h0000, -1, 2);
    // R6: odd sample count 5 -> interval 2
    run_case("R6", 16'h0401, 16'h0000, 16'h0401, 16'h0000, -1, 4);
    // R3: high-speed word overrides normal
    run_case("R3", 16'h0705, 16'h2303, 16'h0705, 16'h2303, -1, 4);
    // R3: high-speed max sample 8 step 8
    run_case("R3", 16'h0000, 16'h7703, 16'h0000, 16'h7703, -1, 2);
    // R4: enable bits not both set -> normal
    run_case("R4", 16'h0201, 16'h7702, 16'h0201, 16'h7702, -1, 4);
    // R8: normal -> other normal mid-half
    run_case("R8", 16'h0302, 16'h0000, 16'h0100, 16'h0000, 5, 5);
    // R8: normal -> high-speed mid-half, mode flips only at boundary
    run_case("R8", 16'h0101, 16'h0000, 16'h0101, 16'h1203, 3, 5);
    // R8: high-speed -> disabled (zero word)
    run_case("R8", 16'h0200, 16'h3103, 16'h0200, 16'h0000, 7, 5);
    t_idle_abort();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chk("R1", "watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule